// File: doc/BRIEF.md
# Bit-Serial SIMD Mesh Array

This block is a two-dimensional grid of one-bit processing elements that all carry out the same instruction in the same clock cycle. A controller drives an opcode, one memory bit address, a mask-enable flag and an edge topology select to every element at once. Each element has a small bit-addressable local memory, an accumulator bit, a carry bit, a mask bit and a neighbour-exchange bit. Multi-bit arithmetic is built by the controller as a sequence of single-bit steps. Operand length is therefore set only by how many steps it issues.

Elements trade data only with their four nearest neighbours. At run time the array edges can be open (plane), wrapped east-west (cylinder), joined into one row-major chain (daisy-chain), or wrapped in both directions (torus). An inclusive-OR over every accumulator bit is registered and returned as one status bit. The controller uses it for parallel searches such as finding a maximum. A row-wide port loads or reads one bit per column of local memory at the broadcast address.

Top module: `simd_mesh`

## Requirements
- R1: After reset, every accumulator, carry, mask and exchange bit is 0 and `status` is 0.
- R2: With `ld_en` high, `ld_data` bit c is written at the rising edge into the memory bit `addr` of the element at row `ld_row`, column c. Element (r,c) has flat index r*COLS+c. `ul_data` bit c shows the memory bit `addr` of element (`ul_row`, c) combinationally.
- R3: Opcodes (4 bits): 0 NOP, 1 LDA (acc=mem), 2 STA (mem=acc), 3 LDN (exch=mem), 4 NTA (acc=exch), 5 LDM (mask=mem), 6 CLC (carry=0), 7 ADD, 8 AND (acc&=mem), 9 OR, 10 XOR, 11 NOT (acc=~acc), 12 SHN, 13 SHE, 14 SHS, 15 SHW. NOP changes no element state.
- R4: ADD writes acc^mem^carry to memory bit `addr` and sets carry to the majority of the three. A sequence of CLC followed by ADD steps from the least significant bit up gives the correct multi-bit sum and final carry.
- R5: When `masked` is 1, only elements whose mask bit is 1 change accumulator, carry, mask, exchange or memory. Elements whose mask bit is 0 keep their state. When `masked` is 0, all elements update.
- R6: Shifts move each exchange bit one element north, east, south or west (SHN/SHE/SHS/SHW). With `topo`=0 (plane), an element on the edge facing the source side receives 0.
- R7: With `topo`=1 (cylinder), east/west shifts wrap within each row, and north/south shifts behave as in plane mode.
- R8: With `topo`=2 (daisy-chain), east/west shifts follow flat index order. The last column of one row feeds the first column of the next, and the two chain ends receive 0. North/south shifts behave as in plane mode.
- R9: With `topo`=3 (torus), shifts wrap in both dimensions.
- R10: `status` equals the OR of all accumulator bits as they stand after the most recent clock edge, so it is valid one cycle after the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Broadcast opcode |
| addr | input | AW | Broadcast memory bit address |
| masked | input | 1 | Gate the instruction by each element's mask bit |
| topo | input | 2 | Edge topology: 0 plane, 1 cylinder, 2 daisy-chain, 3 torus |
| status | output | 1 | Registered OR of all accumulators |
| ld_en | input | 1 | Write one row of memory at `addr` |
| ld_row | input | RW | Row written by the load port |
| ld_data | input | COLS | Bits to load, one per column |
| ul_row | input | RW | Row shown on the unload port |
| ul_data | output | COLS | Memory bits at `addr` of row `ul_row` |

## Verification
On every cycle the assertions check several properties. Carry clear takes effect, and elements with mask 0 keep their accumulator under a masked instruction. NOP leaves all element state unchanged, and the status bit tracks the OR of the accumulators. Corner elements at the edges get the right wrap or zero fill in each topology. Only the bench scenarios can show end-to-end behaviour. Those scenarios cover whole multi-bit sums, shifts of full planes in every direction and topology, including masked shifts, and a maximum search driven by the status bit. Each of them is compared with an integer or coordinate-based reference.

// File: rtl/simd_mesh.sv
module simd_mesh #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int MEM_BITS = 16,
  localparam int NPE = ROWS * COLS,
  localparam int AW = $clog2(MEM_BITS),
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op,
  input  logic [AW-1:0]   addr,
  input  logic            masked,
  input  logic [1:0]      topo,
  output logic            status,
  input  logic            ld_en,
  input  logic [RW-1:0]   ld_row,
  input  logic [COLS-1:0] ld_data,
  input  logic [RW-1:0]   ul_row,
  output logic [COLS-1:0] ul_data
);

  localparam logic [3:0] OP_NOP = 4'd0,  OP_LDA = 4'd1,  OP_STA = 4'd2,  OP_LDN = 4'd3;
  localparam logic [3:0] OP_NTA = 4'd4,  OP_LDM = 4'd5,  OP_CLC = 4'd6,  OP_ADD = 4'd7;
  localparam logic [3:0] OP_AND = 4'd8,  OP_OR  = 4'd9,  OP_XOR = 4'd10, OP_NOT = 4'd11;
  localparam logic [3:0] OP_SHN = 4'd12, OP_SHE = 4'd13, OP_SHS = 4'd14, OP_SHW = 4'd15;
  localparam logic [1:0] T_PLANE = 2'd0, T_CYL = 2'd1, T_DAISY = 2'd2, T_TORUS = 2'd3;

  logic [NPE-1:0] acc, cy, msk, nb;
  logic [NPE-1:0] mem [MEM_BITS];
  logic [NPE-1:0] acc_n, cy_n, msk_n, nb_n, wr;
  logic [NPE-1:0] fw, fe, fn, fs;
  logic           we;

  wire [NPE-1:0] rd   = mem[addr];
  wire [NPE-1:0] en   = masked ? msk : '1;
  wire [NPE-1:0] sum  = rd ^ acc ^ cy;
  wire [NPE-1:0] cout = (rd & acc) | (rd & cy) | (acc & cy);
  wire wrap_h = (topo == T_CYL) || (topo == T_TORUS);
  wire wrap_v = (topo == T_TORUS);
  wire daisy  = (topo == T_DAISY);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int I = r * COLS + c;
      if (c > 0)             assign fw[I] = nb[I-1];
      else if (r > 0)        assign fw[I] = wrap_h ? nb[I+COLS-1] : (daisy & nb[I-1]);
      else                   assign fw[I] = wrap_h & nb[COLS-1];
      if (c < COLS-1)        assign fe[I] = nb[I+1];
      else if (r < ROWS-1)   assign fe[I] = wrap_h ? nb[I-COLS+1] : (daisy & nb[I+1]);
      else                   assign fe[I] = wrap_h & nb[I-COLS+1];
      if (r > 0)             assign fn[I] = nb[I-COLS];
      else                   assign fn[I] = wrap_v & nb[I+NPE-COLS];
      if (r < ROWS-1)        assign fs[I] = nb[I+COLS];
      else                   assign fs[I] = wrap_v & nb[c];
    end
  end

  always_comb begin
    acc_n = acc; cy_n = cy; msk_n = msk; nb_n = nb; wr = rd; we = 1'b0;
    case (op)
      OP_LDA: acc_n = rd;
      OP_STA: begin wr = acc; we = 1'b1; end
      OP_LDN: nb_n = rd;
      OP_NTA: acc_n = nb;
      OP_LDM: msk_n = rd;
      OP_CLC: cy_n = '0;
      OP_ADD: begin wr = sum; cy_n = cout; we = 1'b1; end
      OP_AND: acc_n = acc & rd;
      OP_OR:  acc_n = acc | rd;
      OP_XOR: acc_n = acc ^ rd;
      OP_NOT: acc_n = ~acc;
      OP_SHN: nb_n = fs;
      OP_SHE: nb_n = fw;
      OP_SHS: nb_n = fn;
      OP_SHW: nb_n = fe;
      default: ;
    endcase
    acc_n = (acc_n & en) | (acc & ~en);
    cy_n  = (cy_n  & en) | (cy  & ~en);
    msk_n = (msk_n & en) | (msk & ~en);
    nb_n  = (nb_n  & en) | (nb  & ~en);
    wr    = (wr    & en) | (rd  & ~en);
    if (ld_en) begin
      wr[int'(ld_row)*COLS +: COLS] = ld_data;
      we = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; cy <= '0; msk <= '0; nb <= '0; status <= 1'b0;
    end else begin
      acc <= acc_n; cy <= cy_n; msk <= msk_n; nb <= nb_n;
      status <= |acc_n;
    end
  end

  always_ff @(posedge clk) if (we) mem[addr] <= wr;

  assign ul_data = mem[addr][int'(ul_row)*COLS +: COLS];

  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLC && !masked) |=> (cy == '0)); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (masked && op != OP_NOP) |=> (((acc ^ $past(acc)) & ~$past(msk)) == '0)); // R5
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |=> ($stable(acc) && $stable(cy) && $stable(msk) && $stable(nb))); // R3
  AST_STATUS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (status == (|acc))); // R10
  AST_PLANE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (topo == T_PLANE && op == OP_SHE && !masked) |=> (nb[0] == 1'b0)); // R6
  AST_CYL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (topo == T_CYL && op == OP_SHE && !masked) |=> (nb[0] == $past(nb[COLS-1]))); // R7
  AST_DAISY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (topo == T_DAISY && op == OP_SHE && !masked) |=> (nb[COLS % NPE] == $past(nb[COLS-1]))); // R8
  AST_TORUS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (topo == T_TORUS && op == OP_SHS && !masked) |=> (nb[0] == $past(nb[NPE-COLS]))); // R9

endmodule

// File: tb/simd_mesh_tb.sv
module simd_mesh_tb;
  localparam int ROWS = 8, COLS = 8, MB = 16, NPE = ROWS * COLS, AW = 4, RW = 3;
  localparam logic [3:0] NOP = 0, LDA = 1, STA = 2, LDN = 3, NTA = 4, LDM = 5, CLC = 6, ADD = 7;
  localparam logic [3:0] ANDo = 8, ORo = 9, XORo = 10, NOTo = 11;
  // {masked, topo[1:0], dir[1:0]}, dir 0 N, 1 E, 2 S, 3 W
  localparam logic [4:0] SH_TAB [16] = '{
    5'b0_00_00, 5'b0_00_01, 5'b0_00_10, 5'b0_00_11,
    5'b0_01_00, 5'b0_01_01, 5'b0_01_10, 5'b0_01_11,
    5'b0_10_00, 5'b0_10_01, 5'b0_10_10, 5'b0_10_11,
    5'b0_11_00, 5'b0_11_01, 5'b1_11_10, 5'b1_10_11};

  logic clk = 0, rst_n = 0;
  logic [3:0] op = 0;
  logic [AW-1:0] addr = 0;
  logic masked = 0, ld_en = 0, status;
  logic [1:0] topo = 0;
  logic [RW-1:0] ld_row = 0, ul_row = 0;
  logic [COLS-1:0] ld_data = 0, ul_data;

  simd_mesh #(.ROWS(ROWS), .COLS(COLS), .MEM_BITS(MB)) u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .masked(masked), .topo(topo),
    .status(status), .ld_en(ld_en), .ld_row(ld_row), .ld_data(ld_data),
    .ul_row(ul_row), .ul_data(ul_data));

  always #10 clk = ~clk;

  int total = 0, fails = 0;
  logic [NPE-1:0] m_mem [MB];
  logic [NPE-1:0] m_acc = '0, m_cy = '0, m_msk = '0, m_nb = '0;
  int xv [NPE], yv [NPE];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit src(int d, int tp, int r, int c);
    case (d)
      0: if (r < ROWS-1) return m_nb[(r+1)*COLS+c]; else return (tp == 3) ? m_nb[c] : 1'b0;
      2: if (r > 0) return m_nb[(r-1)*COLS+c]; else return (tp == 3) ? m_nb[(ROWS-1)*COLS+c] : 1'b0;
      1: if (c > 0) return m_nb[r*COLS+c-1];
         else if (tp == 1 || tp == 3) return m_nb[r*COLS+COLS-1];
         else if (tp == 2 && r > 0) return m_nb[r*COLS-1];
         else return 1'b0;
      default: if (c < COLS-1) return m_nb[r*COLS+c+1];
         else if (tp == 1 || tp == 3) return m_nb[r*COLS];
         else if (tp == 2 && r < ROWS-1) return m_nb[(r+1)*COLS];
         else return 1'b0;
    endcase
  endfunction

  task automatic m_exec(input logic [3:0] o, input int a, input bit mk, input int tp);
    logic [NPE-1:0] en = mk ? m_msk : '1;
    logic [NPE-1:0] rdv = m_mem[a];
    logic [NPE-1:0] na = m_acc, nc = m_cy, nm = m_msk, nn = m_nb, nw = m_mem[a];
    for (int i = 0; i < NPE; i++) begin
      if (en[i]) begin
        case (o)
          LDA: na[i] = rdv[i];
          STA: nw[i] = m_acc[i];
          LDN: nn[i] = rdv[i];
          NTA: na[i] = m_nb[i];
          LDM: nm[i] = rdv[i];
          CLC: nc[i] = 1'b0;
          ADD: begin
            nw[i] = rdv[i] ^ m_acc[i] ^ m_cy[i];
            nc[i] = (rdv[i] & m_acc[i]) | (rdv[i] & m_cy[i]) | (m_acc[i] & m_cy[i]);
          end
          ANDo: na[i] = m_acc[i] & rdv[i];
          ORo:  na[i] = m_acc[i] | rdv[i];
          XORo: na[i] = m_acc[i] ^ rdv[i];
          NOTo: na[i] = ~m_acc[i];
          NOP: ;
          default: nn[i] = src(int'(o) - 12, tp, i / COLS, i % COLS);
        endcase
      end
    end
    m_acc = na; m_cy = nc; m_msk = nm; m_nb = nn; m_mem[a] = nw;
  endtask

  task automatic exec(input logic [3:0] o, input int a, input bit mk = 0, input int tp = 0);
    @(negedge clk);
    op = o; addr = a[AW-1:0]; masked = mk; topo = tp[1:0];
    @(posedge clk); #2;
    op = NOP; masked = 0;
    m_exec(o, a, mk, tp);
  endtask

  task automatic load_plane(input int a, input logic [NPE-1:0] v);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      ld_en = 1; addr = a[AW-1:0]; ld_row = r[RW-1:0]; ld_data = v[r*COLS +: COLS];
      @(posedge clk); #2;
      ld_en = 0;
    end
    m_mem[a] = v;
  endtask

  task automatic check_plane(input int a, input logic [NPE-1:0] exp, input string req);
    addr = a[AW-1:0];
    for (int r = 0; r < ROWS; r++) begin
      ul_row = r[RW-1:0]; #1;
      chk(ul_data === exp[r*COLS +: COLS], req, 64'(ul_data), 64'(exp[r*COLS +: COLS]));
    end
  endtask

  function automatic logic [NPE-1:0] rnd_plane();
    return {$urandom, $urandom};
  endfunction

  task automatic add_run(input bit mk);
    logic [NPE-1:0] mp = rnd_plane();
    logic [NPE-1:0] e;
    for (int i = 0; i < NPE; i++) begin xv[i] = $urandom % 16; yv[i] = $urandom % 16; end
    for (int b = 0; b < 4; b++) begin
      logic [NPE-1:0] px, py;
      for (int i = 0; i < NPE; i++) begin px[i] = xv[i][b]; py[i] = yv[i][b]; end
      load_plane(b, px); load_plane(4 + b, py);
    end
    load_plane(8, '0);
    load_plane(9, mp);
    exec(LDM, 9);
    exec(CLC, 0);
    for (int b = 0; b < 4; b++) begin
      exec(LDA, 4 + b);
      exec(ADD, b, mk);
    end
    exec(LDA, 8, mk);
    exec(ADD, 8, mk);
    for (int b = 0; b < 5; b++) begin
      for (int i = 0; i < NPE; i++) begin
        int s = (!mk || mp[i]) ? xv[i] + yv[i] : xv[i];
        e[i] = (b < 4) ? s[b] : ((!mk || mp[i]) ? s[4] : 1'b0);
      end
      check_plane(b < 4 ? b : 8, e, mk ? "R5 masked add" : "R4 add");
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [NPE-1:0] p, q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(status == 1'b0, "R1 status", 64'(status), 0);
    exec(STA, 14);
    check_plane(14, '0, "R1 accumulator");
    exec(NTA, 0); exec(STA, 15);
    check_plane(15, '0, "R1 exchange");
    load_plane(13, '1);
    exec(LDA, 13, 1);
    exec(STA, 14);
    check_plane(14, '0, "R1 mask zero");
    load_plane(12, '0);
    exec(ADD, 12);
    check_plane(12, '0, "R1 carry zero");

    // R2 load and unload
    p = rnd_plane();
    load_plane(3, p);
    check_plane(3, p, "R2 row port");

    // R3 logic ops
    p = rnd_plane(); q = rnd_plane();
    load_plane(0, p); load_plane(1, q);
    exec(LDA, 0); exec(XORo, 1); exec(STA, 2); check_plane(2, p ^ q, "R3 xor");
    exec(LDA, 0); exec(ANDo, 1); exec(STA, 2); check_plane(2, p & q, "R3 and");
    exec(LDA, 0); exec(ORo, 1); exec(STA, 2); check_plane(2, p | q, "R3 or");
    exec(LDA, 0); exec(NOTo, 0); exec(NOP, 2); exec(STA, 2); check_plane(2, ~p, "R3 not nop");

    // R4 unmasked and R5 masked multi-bit add
    add_run(0);
    add_run(1);

    // R6..R9 shifts from the table
    load_plane(11, rnd_plane());
    exec(LDM, 11);
    foreach (SH_TAB[k]) begin
      string tag;
      int tp = int'(SH_TAB[k][3:2]);
      case (tp)
        0: tag = "R6 plane shift";
        1: tag = "R7 cylinder shift";
        2: tag = "R8 daisy shift";
        default: tag = "R9 torus shift";
      endcase
      if (SH_TAB[k][4]) tag = {tag, " R5 masked"};
      load_plane(9, rnd_plane());
      exec(LDN, 9);
      exec(4'(12 + SH_TAB[k][1:0]), 0, SH_TAB[k][4], tp);
      exec(NTA, 0);
      exec(STA, 10);
      check_plane(10, m_mem[10], tag);
    end

    // R10 status and max search over 4-bit values at planes 0..3
    load_plane(12, '0);
    exec(LDA, 12);
    chk(status == 1'b0, "R10 status zero", 64'(status), 0);
    for (int i = 0; i < NPE; i++) xv[i] = $urandom % 12;
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < NPE; i++) p[i] = xv[i][b];
      load_plane(b, p);
    end
    load_plane(12, '1);
    begin
      int found = 0, maxv = 0;
      for (int i = 0; i < NPE; i++) if (xv[i] > maxv) maxv = xv[i];
      for (int b = 3; b >= 0; b--) begin
        exec(LDA, b);
        exec(ANDo, 12);
        chk(status == (|m_acc), "R10 status step", 64'(status), 64'(|m_acc));
        if (status) begin exec(STA, 12); found |= (1 << b); end
      end
      chk(found == maxv, "R10 max search", 64'(found), 64'(maxv));
      for (int i = 0; i < NPE; i++) p[i] = (xv[i] == maxv);
      check_plane(12, p, "R10 max holders");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule